// File: doc/BRIEF.md
# Streaming Video FIFO Bridge

This block sits between a pixel-streaming video bus and the write and read FIFOs of a frame-buffer memory controller. On the capture side, each pixel seen while the active-video qualifier is high is pushed into the controller's write FIFO. On the display side, the active-video qualifier pops the read FIFO. The sync and blanking controls are held for one read clock so that they arrive together with the data, which the FIFO returns one cycle after the pop.

A small sequencer in a third clock domain turns frame starts into frame commands for the controller. The target addresses come from configuration inputs. Each vertical sync is resynchronised into that domain, and every rising edge yields exactly one command. When a write frame and a read frame start together, the write command always goes out first. With frame sync turned off, the sequencer alternates write and read commands back to back, each issued as soon as the previous one is acknowledged.

The FIFO level flags pass straight through to the block's outputs. Pushing into a full write FIFO sets a sticky error flag, and so does popping an empty read FIFO. Each flag is cleared by its own clear strobe.

Top module: `vfb_stream_bridge`

## Requirements
- R1: `wf_push` equals `wr_active` in the same write clock, and `wf_data` carries `wr_pixel` unchanged. No push happens while `wr_active` is low.
- R2: A push while `wf_full` is high sets `wr_overflow` on the next write clock. The flag stays high until a write clock on which `wr_err_clr` is high clears it.
- R3: `rd_vsync_o`, `rd_hsync_o`, `rd_blank_o` and `rd_active_o` equal the values of `rd_vsync`, `rd_hsync`, `rd_blank` and `rd_active` from exactly one read clock earlier.
- R4: The read stream is armed only once the read FIFO holds data. A rising edge of `rd_vsync` disarms it on that clock. It re-arms on the first later read clock on which `rf_empty` is low. `rf_pop` is `rd_active` gated by the armed state.
- R5: A pop while `rf_empty` is high sets `rd_underflow` on the next read clock. The flag stays high until a read clock on which `rd_err_clr` is high clears it.
- R6: `wr_full_o`, `wr_afull_o`, `rd_empty_o` and `rd_aempty_o` follow `wf_full`, `wf_afull`, `rf_empty` and `rf_aempty` combinationally. `rd_pixel` follows `rf_data`.
- R7: With `cfg_fsync_en` high, each rising edge of `wr_vsync` yields exactly one write command (`cmd_is_read`=0, `cmd_addr`=`cfg_wr_base`). Each rising edge of `rd_vsync` yields exactly one read command (`cmd_is_read`=1, `cmd_addr`=`cfg_rd_base`).
- R8: When a write command and a read command are both pending, the write command is handshaken first.
- R9: While `cmd_valid` is high and `cmd_ack` is low, `cmd_valid`, `cmd_is_read` and `cmd_addr` stay unchanged, even if the configuration bases change.
- R10: With `cfg_fsync_en` low, commands alternate write, read, write, read with no idle cycle between them, and each advances on a handshake (`cmd_valid` and `cmd_ack` both high).
- R11: After reset, `cmd_valid`, `wr_overflow`, `rd_underflow` and the four delayed controls are low, and `rf_pop` is low until the read FIFO reports data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous active-low reset |
| wr_vsync | input | 1 | Write frame start |
| wr_active | input | 1 | Write active-video qualifier |
| wr_pixel | input | PIX_W | Incoming pixel |
| wr_err_clr | input | 1 | Clears the overflow flag |
| wf_push | output | 1 | Write-FIFO push |
| wf_data | output | PIX_W | Write-FIFO data |
| wf_full | input | 1 | Write FIFO full |
| wf_afull | input | 1 | Write FIFO almost full |
| wr_full_o | output | 1 | Write FIFO full, passed out |
| wr_afull_o | output | 1 | Write FIFO almost full, passed out |
| wr_overflow | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous active-low reset |
| rd_vsync | input | 1 | Read frame start / vertical sync |
| rd_hsync | input | 1 | Horizontal sync |
| rd_blank | input | 1 | Blanking |
| rd_active | input | 1 | Read active video, the pop request |
| rd_err_clr | input | 1 | Clears the underflow flag |
| rd_vsync_o | output | 1 | Vertical sync, one read clock later |
| rd_hsync_o | output | 1 | Horizontal sync, one read clock later |
| rd_blank_o | output | 1 | Blanking, one read clock later |
| rd_active_o | output | 1 | Active video, one read clock later |
| rd_pixel | output | PIX_W | Outgoing pixel |
| rf_pop | output | 1 | Read-FIFO pop |
| rf_data | input | PIX_W | Read-FIFO data (one-cycle latency) |
| rf_empty | input | 1 | Read FIFO empty |
| rf_aempty | input | 1 | Read FIFO almost empty |
| rd_empty_o | output | 1 | Read FIFO empty, passed out |
| rd_aempty_o | output | 1 | Read FIFO almost empty, passed out |
| rd_underflow | output | 1 | Sticky underflow flag |
| cmd_clk | input | 1 | Command-domain clock |
| cmd_rst_n | input | 1 | Command-domain synchronous active-low reset |
| cfg_fsync_en | input | 1 | 1: commands follow the frame syncs; 0: commands run back to back |
| cfg_wr_base | input | ADDR_W | Write frame base address |
| cfg_rd_base | input | ADDR_W | Read frame base address |
| cmd_valid | output | 1 | Command offered |
| cmd_ack | input | 1 | Command accepted |
| cmd_is_read | output | 1 | 0 = write command, 1 = read command |
| cmd_addr | output | ADDR_W | Command base address |

## Verification
The bench raises both frame syncs on the same clock to check the ordering. A sequencer that tests the read request first would hand the scoreboard a read before the write. The bench holds back the acknowledge and changes the base address during the stall. A design that re-reads the configuration or drops `cmd_valid` would show a changed or missing command. A new read frame with data already waiting is also exercised: the pop must vanish for exactly one clock, and a design that skipped the disarm, or re-armed late, would pop too early or lose pixels. Pushing into a full FIFO and popping an empty one, each followed by idle cycles and then a clear, shows whether the error flags are truly sticky and whether the clear strobe resets them.

// File: rtl/vfb_pkg.sv
// Shared types of the streaming video FIFO bridge.
// Assumes: nothing beyond standard SystemVerilog packed types.
package vfb_pkg;

    // Video control bundle carried on the read side.
    typedef struct packed {
        logic vsync;
        logic hsync;
        logic blank;
        logic active;
    } vid_ctrl_t;

    // Command sequencer state.
    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WR   = 2'd1,
        CS_RD   = 2'd2
    } cmd_state_t;

endpackage

// File: rtl/vfb_sync_edge.sv
// Multi-flop synchroniser followed by rising-edge detection.
// Assumes: the asynchronous input stays high for at least two destination clocks.
module vfb_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the input through the synchroniser and one extra history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], async_i};
    end

    // Rising edge seen on the synchronised level.
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/vfb_wr_port.sv
// Write-side port: forwards qualified pixels to the write FIFO and keeps a
// sticky overflow flag. Assumes: FIFO flags are valid in the write clock domain.
module vfb_wr_port #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [PIX_W-1:0] pixel_i,
    input  logic             err_clr_i,
    input  logic             full_i,
    output logic             push_o,
    output logic [PIX_W-1:0] data_o,
    output logic             overflow_o
);
    logic ovf_q;

    assign push_o     = active_i;
    assign data_o     = pixel_i;
    assign overflow_o = ovf_q;

    // Latch a push into a full FIFO until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (err_clr_i) ovf_q <= 1'b0;
        else if (push_o && full_i) ovf_q <= 1'b1;
    end

    assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && full_i && !err_clr_i) |=> overflow_o);

    assert_overflow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !err_clr_i) |=> overflow_o);
endmodule

// File: rtl/vfb_rd_port.sv
// Read-side port: gates pops until the read FIFO has data in the current
// frame, delays video controls by one clock to match the FIFO read latency,
// and keeps a sticky underflow flag. Assumes: the FIFO returns data one clock
// after a pop.
module vfb_rd_port
    import vfb_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vid_ctrl_t        ctrl_i,
    input  logic             err_clr_i,
    input  logic             empty_i,
    input  logic [PIX_W-1:0] fifo_data_i,
    output vid_ctrl_t        ctrl_o,
    output logic             pop_o,
    output logic [PIX_W-1:0] pixel_o,
    output logic             underflow_o
);
    logic      vs_q;
    logic      armed_q;
    logic      unf_q;
    logic      frame_rise;
    vid_ctrl_t ctrl_q;
    logic      seen_q;

    assign frame_rise  = ctrl_i.vsync & ~vs_q;
    assign pop_o       = ctrl_i.active & armed_q;
    assign pixel_o     = fifo_data_i;
    assign ctrl_o      = ctrl_q;
    assign underflow_o = unf_q;

    // Delay controls one clock and remember vsync for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            vs_q   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_i;
            vs_q   <= ctrl_i.vsync;
        end
    end

    // Disarm at each frame start, arm once the FIFO reports data.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b0;
        else if (frame_rise) armed_q <= 1'b0;
        else if (!empty_i)   armed_q <= 1'b1;
    end

    // Latch a pop from an empty FIFO until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         unf_q <= 1'b0;
        else if (err_clr_i) unf_q <= 1'b0;
        else if (pop_o && empty_i) unf_q <= 1'b1;
    end

    // Marks that at least one clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_ctrl_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (ctrl_o == $past(ctrl_i)));

    assert_underflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o && empty_i && !err_clr_i) |=> underflow_o);

    assert_disarm_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rise |=> !pop_o);
endmodule

// File: rtl/vfb_cmd_seq.sv
// Command sequencer: turns synchronised frame starts into write/read
// commands with a valid/ack handshake, write before read. With frame sync
// off it alternates commands back to back. Assumes: address bases are
// quasi-static and sampled when a command is issued.
module vfb_cmd_seq
    import vfb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_en_i,
    input  logic              wr_rise_i,
    input  logic              rd_rise_i,
    input  logic [ADDR_W-1:0] wr_base_i,
    input  logic [ADDR_W-1:0] rd_base_i,
    input  logic              ack_i,
    output logic              valid_o,
    output logic              is_read_o,
    output logic [ADDR_W-1:0] addr_o
);
    cmd_state_t        state_q;
    logic              wr_pend_q;
    logic              rd_pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              want_wr;
    logic              want_rd;

    assign valid_o   = (state_q != CS_IDLE);
    assign is_read_o = (state_q == CS_RD);
    assign addr_o    = addr_q;
    assign accept    = valid_o & ack_i;
    assign want_wr   = fsync_en_i ? wr_pend_q : 1'b1;
    assign want_rd   = fsync_en_i ? rd_pend_q : 1'b1;

    // Track one pending request per frame-start edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !fsync_en_i) begin
            wr_pend_q <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            wr_pend_q <= (wr_pend_q & ~(accept & (state_q == CS_WR))) | wr_rise_i;
            rd_pend_q <= (rd_pend_q & ~(accept & (state_q == CS_RD))) | rd_rise_i;
        end
    end

    // Issue commands, write first, holding each until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                CS_IDLE: begin
                    if (want_wr) begin
                        state_q <= CS_WR;
                        addr_q  <= wr_base_i;
                    end else if (want_rd) begin
                        state_q <= CS_RD;
                        addr_q  <= rd_base_i;
                    end
                end
                CS_WR: begin
                    if (accept) begin
                        if (want_rd) begin
                            state_q <= CS_RD;
                            addr_q  <= rd_base_i;
                        end else begin
                            state_q <= CS_IDLE;
                        end
                    end
                end
                CS_RD: begin
                    if (accept) begin
                        if (want_wr) begin
                            state_q <= CS_WR;
                            addr_q  <= wr_base_i;
                        end else begin
                            state_q <= CS_IDLE;
                        end
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (valid_o && $stable(addr_o) && $stable(is_read_o)));

    assert_alternate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_en_i && accept && $stable(fsync_en_i)) |=> (valid_o && (is_read_o != $past(is_read_o))));
endmodule

// File: rtl/vfb_stream_bridge.sv
// Top of the streaming video FIFO bridge: write port, read port, two frame
// start synchronisers and the command sequencer. Assumes: three independent
// clocks; each vsync is held high for at least two command clocks.
module vfb_stream_bridge
    import vfb_pkg::*;
#(
    parameter int PIX_W     = 24,
    parameter int ADDR_W    = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_vsync,
    input  logic              wr_active,
    input  logic [PIX_W-1:0]  wr_pixel,
    input  logic              wr_err_clr,
    output logic              wf_push,
    output logic [PIX_W-1:0]  wf_data,
    input  logic              wf_full,
    input  logic              wf_afull,
    output logic              wr_full_o,
    output logic              wr_afull_o,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_vsync,
    input  logic              rd_hsync,
    input  logic              rd_blank,
    input  logic              rd_active,
    input  logic              rd_err_clr,
    output logic              rd_vsync_o,
    output logic              rd_hsync_o,
    output logic              rd_blank_o,
    output logic              rd_active_o,
    output logic [PIX_W-1:0]  rd_pixel,
    output logic              rf_pop,
    input  logic [PIX_W-1:0]  rf_data,
    input  logic              rf_empty,
    input  logic              rf_aempty,
    output logic              rd_empty_o,
    output logic              rd_aempty_o,
    output logic              rd_underflow,
    input  logic              cmd_clk,
    input  logic              cmd_rst_n,
    input  logic              cfg_fsync_en,
    input  logic [ADDR_W-1:0] cfg_wr_base,
    input  logic [ADDR_W-1:0] cfg_rd_base,
    output logic              cmd_valid,
    input  logic              cmd_ack,
    output logic              cmd_is_read,
    output logic [ADDR_W-1:0] cmd_addr
);
    vid_ctrl_t rd_ctrl_in;
    vid_ctrl_t rd_ctrl_out;
    logic      wr_rise;
    logic      rd_rise;

    assign rd_ctrl_in  = '{vsync: rd_vsync, hsync: rd_hsync, blank: rd_blank, active: rd_active};
    assign rd_vsync_o  = rd_ctrl_out.vsync;
    assign rd_hsync_o  = rd_ctrl_out.hsync;
    assign rd_blank_o  = rd_ctrl_out.blank;
    assign rd_active_o = rd_ctrl_out.active;

    assign wr_full_o   = wf_full;
    assign wr_afull_o  = wf_afull;
    assign rd_empty_o  = rf_empty;
    assign rd_aempty_o = rf_aempty;

    vfb_wr_port #(.PIX_W(PIX_W)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .active_i   (wr_active),
        .pixel_i    (wr_pixel),
        .err_clr_i  (wr_err_clr),
        .full_i     (wf_full),
        .push_o     (wf_push),
        .data_o     (wf_data),
        .overflow_o (wr_overflow)
    );

    vfb_rd_port #(.PIX_W(PIX_W)) u_rd (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .ctrl_i      (rd_ctrl_in),
        .err_clr_i   (rd_err_clr),
        .empty_i     (rf_empty),
        .fifo_data_i (rf_data),
        .ctrl_o      (rd_ctrl_out),
        .pop_o       (rf_pop),
        .pixel_o     (rd_pixel),
        .underflow_o (rd_underflow)
    );

    vfb_sync_edge #(.STAGES(SYNC_STGS)) u_wr_sync (
        .clk     (cmd_clk),
        .rst_n   (cmd_rst_n),
        .async_i (wr_vsync),
        .rise_o  (wr_rise)
    );

    vfb_sync_edge #(.STAGES(SYNC_STGS)) u_rd_sync (
        .clk     (cmd_clk),
        .rst_n   (cmd_rst_n),
        .async_i (rd_vsync),
        .rise_o  (rd_rise)
    );

    vfb_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (cmd_clk),
        .rst_n      (cmd_rst_n),
        .fsync_en_i (cfg_fsync_en),
        .wr_rise_i  (wr_rise),
        .rd_rise_i  (rd_rise),
        .wr_base_i  (cfg_wr_base),
        .rd_base_i  (cfg_rd_base),
        .ack_i      (cmd_ack),
        .valid_o    (cmd_valid),
        .is_read_o  (cmd_is_read),
        .addr_o     (cmd_addr)
    );
endmodule

// File: tb/sim_vfb_stream_bridge.sv
// Scoreboard bench: drivers queue expected commands, a monitor checks them.
module sim_vfb_stream_bridge;
    localparam int PIX_W  = 24;
    localparam int ADDR_W = 32;
    localparam logic [ADDR_W-1:0] WBASE = 32'h0000_1000;
    localparam logic [ADDR_W-1:0] RBASE = 32'h0000_2000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic wr_vsync, wr_active, wr_err_clr, wf_full, wf_afull;
    logic [PIX_W-1:0] wr_pixel, rf_data;
    logic rd_vsync, rd_hsync, rd_blank, rd_active, rd_err_clr, rf_empty, rf_aempty;
    logic cfg_fsync_en, cmd_ack;
    logic [ADDR_W-1:0] cfg_wr_base, cfg_rd_base;
    logic wf_push, wr_full_o, wr_afull_o, wr_overflow;
    logic [PIX_W-1:0] wf_data, rd_pixel;
    logic rd_vsync_o, rd_hsync_o, rd_blank_o, rd_active_o, rf_pop;
    logic rd_empty_o, rd_aempty_o, rd_underflow;
    logic cmd_valid, cmd_is_read;
    logic [ADDR_W-1:0] cmd_addr;

    vfb_stream_bridge #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u0 (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_vsync(wr_vsync), .wr_active(wr_active),
        .wr_pixel(wr_pixel), .wr_err_clr(wr_err_clr), .wf_push(wf_push), .wf_data(wf_data),
        .wf_full(wf_full), .wf_afull(wf_afull), .wr_full_o(wr_full_o), .wr_afull_o(wr_afull_o),
        .wr_overflow(wr_overflow),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_vsync(rd_vsync), .rd_hsync(rd_hsync),
        .rd_blank(rd_blank), .rd_active(rd_active), .rd_err_clr(rd_err_clr),
        .rd_vsync_o(rd_vsync_o), .rd_hsync_o(rd_hsync_o), .rd_blank_o(rd_blank_o),
        .rd_active_o(rd_active_o), .rd_pixel(rd_pixel), .rf_pop(rf_pop), .rf_data(rf_data),
        .rf_empty(rf_empty), .rf_aempty(rf_aempty), .rd_empty_o(rd_empty_o),
        .rd_aempty_o(rd_aempty_o), .rd_underflow(rd_underflow),
        .cmd_clk(clk), .cmd_rst_n(rst_n), .cfg_fsync_en(cfg_fsync_en),
        .cfg_wr_base(cfg_wr_base), .cfg_rd_base(cfg_rd_base), .cmd_valid(cmd_valid),
        .cmd_ack(cmd_ack), .cmd_is_read(cmd_is_read), .cmd_addr(cmd_addr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [ADDR_W:0] exp_q[$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic rd, input logic [ADDR_W-1:0] a);
        exp_q.push_back({rd, a});
    endtask

    // Monitor: every handshake must match the front of the scoreboard (R7, R8, R10).
    always @(negedge clk) begin
        #2;
        if (rst_n && cmd_valid && cmd_ack && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected command actual=%0h expected=none", {cmd_is_read, cmd_addr});
            end else begin
                logic [ADDR_W:0] e;
                e = exp_q.pop_front();
                if ({cmd_is_read, cmd_addr} !== e) begin
                    fails++;
                    $display("FAIL R8 command order actual=%0h expected=%0h", {cmd_is_read, cmd_addr}, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        wr_vsync = 0; wr_active = 0; wr_err_clr = 0; wf_full = 0; wf_afull = 0;
        wr_pixel = '0; rf_data = '0;
        rd_vsync = 0; rd_hsync = 0; rd_blank = 0; rd_active = 0; rd_err_clr = 0;
        rf_empty = 1; rf_aempty = 1;
        cfg_fsync_en = 1; cmd_ack = 1; cfg_wr_base = WBASE; cfg_rd_base = RBASE;
        step(4);
        rst_n = 1'b1;
        step(1); #2;
        // R11: reset state.
        chk("R11 cmd_valid", cmd_valid, 0);
        chk("R11 flags", {wr_overflow, rd_underflow}, 0);
        chk("R11 ctrl out", {rd_vsync_o, rd_hsync_o, rd_blank_o, rd_active_o}, 0);
        rd_active = 1; #1;
        chk("R11 no pop before data", rf_pop, 0);
        rd_active = 0;

        // R1: push qualification and data pass-through.
        step(1); wr_pixel = 24'hABCDEF; wr_active = 0; #2;
        chk("R1 no push when inactive", wf_push, 0);
        step(1); wr_active = 1; wr_pixel = 24'h123456; #2;
        chk("R1 push when active", wf_push, 1);
        chk("R1 pixel data", wf_data, 24'h123456);

        // R6: status pass-through.
        wf_full = 0; wf_afull = 1; rf_empty = 1; rf_aempty = 0; rf_data = 24'h55AA33; #1;
        chk("R6 flags", {wr_full_o, wr_afull_o, rd_empty_o, rd_aempty_o}, 4'b0110);
        chk("R6 read pixel", rd_pixel, 24'h55AA33);

        // R2: overflow sticky and clear.
        step(1); wr_active = 0; wf_full = 1;
        step(1); #2;
        chk("R2 no overflow without push", wr_overflow, 0);
        wr_active = 1;
        step(1); wr_active = 0; #2;
        chk("R2 overflow set", wr_overflow, 1);
        step(2); #2;
        chk("R2 overflow sticky", wr_overflow, 1);
        wr_err_clr = 1;
        step(1); wr_err_clr = 0; wf_full = 0; #2;
        chk("R2 overflow cleared", wr_overflow, 0);

        // R3: control delay scoreboard over a varied pattern.
        begin
            logic [3:0] prev;
            prev = {rd_vsync, rd_hsync, rd_blank, rd_active};
            for (int k = 0; k < 10; k++) begin
                logic [3:0] v;
                step(1);
                #2;
                chk("R3 ctrl delayed one clock", {rd_vsync_o, rd_hsync_o, rd_blank_o, rd_active_o}, prev);
                v = 4'((k * 5 + 3) % 16) & 4'b0111;
                {rd_vsync, rd_hsync, rd_blank, rd_active} = v;
                prev = v;
            end
            step(1); #2;
            chk("R3 ctrl final", {rd_vsync_o, rd_hsync_o, rd_blank_o, rd_active_o}, prev);
            {rd_vsync, rd_hsync, rd_blank, rd_active} = 4'b0000;
        end
        step(6);

        // R4: read frame start with empty FIFO; pops wait for data.
        expect_cmd(1'b1, RBASE);
        rf_empty = 1; rd_active = 1; rd_vsync = 1;
        step(2); #2;
        chk("R4 no pop while empty", rf_pop, 0);
        step(1); rd_vsync = 0; rf_empty = 0; #2;
        chk("R4 not armed same clock", rf_pop, 0);
        step(1); #2;
        chk("R4 armed after data", rf_pop, 1);

        // R5: underflow sticky and clear.
        step(1); rf_empty = 1;
        step(1); rd_active = 0; #2;
        chk("R5 underflow set", rd_underflow, 1);
        step(2); #2;
        chk("R5 underflow sticky", rd_underflow, 1);
        rd_err_clr = 1;
        step(1); rd_err_clr = 0; #2;
        chk("R5 underflow cleared", rd_underflow, 0);

        // R4: new frame with data waiting drops pop for exactly one clock.
        step(4);
        expect_cmd(1'b1, RBASE);
        rf_empty = 0; rd_active = 1;
        step(1); #2;
        chk("R4 armed before frame", rf_pop, 1);
        rd_vsync = 1;
        step(1); #2;
        chk("R4 disarmed at frame start", rf_pop, 0);
        step(1); #2;
        chk("R4 re-armed next clock", rf_pop, 1);
        step(1); rd_vsync = 0; rd_active = 0;
        step(10);

        // R7: a single write frame start gives one write command.
        expect_cmd(1'b0, WBASE);
        wr_vsync = 1; step(3); wr_vsync = 0;
        step(10);
        chk("R7 write command consumed", exp_q.size(), 0);

        // R8: simultaneous frame starts give write then read.
        expect_cmd(1'b0, WBASE);
        expect_cmd(1'b1, RBASE);
        wr_vsync = 1; rd_vsync = 1; step(3); wr_vsync = 0; rd_vsync = 0;
        step(12);
        chk("R8 both commands consumed", exp_q.size(), 0);

        // R9: stall with changing base address.
        cmd_ack = 0;
        expect_cmd(1'b0, WBASE);
        wr_vsync = 1; step(3); wr_vsync = 0;
        for (int k = 0; k < 20 && !cmd_valid; k++) step(1);
        cfg_wr_base = 32'h0000_5555;
        for (int k = 0; k < 3; k++) begin
            step(1); #2;
            chk("R9 valid held", cmd_valid, 1);
            chk("R9 address held", cmd_addr, WBASE);
        end
        step(1); cfg_wr_base = WBASE; cmd_ack = 1;
        step(6);
        chk("R9 stalled command consumed", exp_q.size(), 0);

        // R10: frame sync off, back-to-back alternation.
        cmd_ack = 0; step(2);
        expect_cmd(1'b0, WBASE);
        expect_cmd(1'b1, RBASE);
        expect_cmd(1'b0, WBASE);
        expect_cmd(1'b1, RBASE);
        cfg_fsync_en = 0; cmd_ack = 1;
        begin
            int n;
            n = 0;
            while (n < 4) begin
                @(negedge clk);
                #3;
                if (cmd_valid) n++;
            end
        end
        @(negedge clk); cmd_ack = 0;
        step(2);
        chk("R10 four alternating commands", exp_q.size(), 0);
        finish_run();
    end
endmodule